// File: doc/BRIEF.md
# DRAM Frequency-Change Sequencer

This block moves an attached DRAM to a new clock frequency without losing its contents. On a start pulse it captures the target settings. It waits for the start of a display blanking interval and stalls the command front end. It turns off the framebuffer and waits for it to go idle, then parks the DRAM in self-refresh. Next it reprograms the memory PLL and waits for the PLL to lock. It then brings refresh back and rewrites the mode registers and all nine timing words. If the DLL is in use it resets the DLL. Last, it turns the framebuffer back on and releases the stall.

Every register change leaves the block as a one-cycle strobe on a single write port (`wr_en`, `wr_addr`, `wr_data`). The surrounding chip decodes the local address. Every fixed pause is counted in clock cycles by one shared down-counter, and the cycle count comes from the `CLK_PERIOD_NS` parameter, rounded up. The PLL dividers and timing words are worked out elsewhere and arrive here ready to use.

Top module: `dram_freq_seq`

## Requirements
- R1: After reset `busy`, `done`, `err` and `wr_en` are 0. While `busy` is 1, a `start` pulse is ignored: the sequence in progress and the settings captured at its start are not changed.
- R2: No write strobe is issued until `vblank` has been seen low and then high after the start.
- R3: The first write is the stall (address 0x01, data 1). The framebuffer-off write (address 0x02, data 0) follows after exactly 8 µs of cycles with no strobe (800 cycles at 10 ns).
- R4: After the framebuffer-off write, the sequence waits for `fb_idle` to be high. It then waits 2 µs before the next write, so that write comes at least 201 cycles after the framebuffer-off strobe.
- R5: Self-refresh entry is written on consecutive cycles in this order: precharge (0x03, 1), refresh (0x04, 1) twice, auto-refresh off (0x05, 0), self-refresh on (0x06, 1).
- R6: The PLL writes follow on consecutive cycles. First comes control (0x07): bit 3 is the low-speed bit, bits 2:0 are P. Then dividers (0x08): N in bits 15:8, M in bits 7:0. Then the partition control (0x09): bit 0 is the low-speed bit. The low-speed bit is 1 when `freq_mhz` ≤ 750 and 0 above that.
- R7: After the partition-control write, 96 µs (9600 cycles) pass with no strobe. Then self-refresh off (0x06, 0) is written.
- R8: Self-refresh exit writes self-refresh off, then precharge (0x03, 1), then auto-refresh on (0x05, 1), on consecutive cycles. A 12 µs (1200-cycle) pause follows.
- R9: With `mem_gddr3`=1, mode register 1 (0x11, `mr1_in`) is written before mode register 0 (0x10, `mr0_in`). With `mem_gddr3`=0, only mode register 0 is written, with `mr0_in`.
- R10: The timing words go to addresses 0x20+i, in the index order 3, 1, 6, 7, 8, 0, 2, 4, 5, on consecutive cycles. Word i is taken from `timing_in[32*i +: 32]`.
- R11: With `dll_off`=0, mode register 0 is written with bit 8 set and then with bit 8 cleared, followed by a 24 µs (2400-cycle) pause. With `dll_off`=1, both writes are left out.
- R12: The sequence ends with framebuffer on (0x02, 1), then a wait for `fb_idle` low, then unstall (0x01, 0). `done` is 1 for exactly the cycle after the unstall strobe, and `busy` is 0 in that cycle.
- R13: If `fb_idle` does not respond within `ACK_TIMEOUT` cycles of an acknowledge wait, `err` goes to 1 and the block returns to idle with no further writes. The next start clears `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a frequency change (ignored while busy) |
| freq_mhz | input | 16 | Target memory frequency in MHz |
| pll_n | input | 8 | PLL feedback divider |
| pll_m | input | 8 | PLL reference divider |
| pll_p | input | 3 | PLL post divider |
| timing_in | input | 288 | Nine 32-bit timing words, word i at bits 32*i+31:32*i |
| mr0_in | input | 32 | Mode register 0 value |
| mr1_in | input | 32 | Mode register 1 value |
| dll_off | input | 1 | Skip the DLL reset when 1 |
| mem_gddr3 | input | 1 | 1 selects the GDDR3 branch, 0 the DDR2 branch |
| vblank | input | 1 | Display blanking indicator |
| fb_idle | input | 1 | High when the framebuffer is disabled |
| wr_en | output | 1 | Register-write strobe |
| wr_addr | output | 8 | Local register address |
| wr_data | output | 32 | Register-write data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse at the end of the sequence |
| err | output | 1 | Acknowledge timeout occurred |

## Verification
The hardest state to reach from the ports is the acknowledge timeout. In normal use the framebuffer acknowledge always arrives. The bench uses a responder model that watches the framebuffer-enable writes and answers them a few cycles later. To reach the timeout it switches the responder off, leaves `fb_idle` stuck, and confirms that exactly two writes appear before `err` rises. It then starts a normal run and checks that `err` clears. The bench also issues a second `start` with different settings while the first run waits for blanking, to show that the captured settings are kept.

// File: rtl/dram_freq_seq.sv
module dram_freq_seq #(
  parameter int CLK_PERIOD_NS = 10,
  parameter int LOW_SPEED_MHZ = 750,
  parameter int ACK_TIMEOUT   = 1024,
  parameter int FREQ_W        = 16,
  parameter int DIV_W         = 8,
  parameter int P_W           = 3,
  parameter int ADDR_W        = 8,
  parameter int DATA_W        = 32,
  parameter int NTIM          = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [FREQ_W-1:0]        freq_mhz,
  input  logic [DIV_W-1:0]         pll_n,
  input  logic [DIV_W-1:0]         pll_m,
  input  logic [P_W-1:0]           pll_p,
  input  logic [NTIM*DATA_W-1:0]   timing_in,
  input  logic [DATA_W-1:0]        mr0_in,
  input  logic [DATA_W-1:0]        mr1_in,
  input  logic                     dll_off,
  input  logic                     mem_gddr3,
  input  logic                     vblank,
  input  logic                     fb_idle,
  output logic                     wr_en,
  output logic [ADDR_W-1:0]        wr_addr,
  output logic [DATA_W-1:0]        wr_data,
  output logic                     busy,
  output logic                     done,
  output logic                     err
);

  function automatic int ns2cyc(int ns);
    return (ns + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  endfunction

  localparam int D_BLOCK = ns2cyc(8000);
  localparam int D_FBOFF = ns2cyc(2000);
  localparam int D_LOCK  = ns2cyc(64000) + ns2cyc(32000);
  localparam int D_REFR  = ns2cyc(12000);
  localparam int D_DLL   = ns2cyc(24000);
  localparam int MAXC    = (D_LOCK > ACK_TIMEOUT) ? D_LOCK : ACK_TIMEOUT;
  localparam int CW      = $clog2(MAXC + 1);
  localparam int TW      = $clog2(NTIM);

  localparam logic [ADDR_W-1:0] A_STALL = ADDR_W'(8'h01);
  localparam logic [ADDR_W-1:0] A_FBEN  = ADDR_W'(8'h02);
  localparam logic [ADDR_W-1:0] A_PRE   = ADDR_W'(8'h03);
  localparam logic [ADDR_W-1:0] A_REF   = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] A_AREF  = ADDR_W'(8'h05);
  localparam logic [ADDR_W-1:0] A_SREF  = ADDR_W'(8'h06);
  localparam logic [ADDR_W-1:0] A_PLLC  = ADDR_W'(8'h07);
  localparam logic [ADDR_W-1:0] A_PLLD  = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] A_PART  = ADDR_W'(8'h09);
  localparam logic [ADDR_W-1:0] A_MR0   = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] A_MR1   = ADDR_W'(8'h11);
  localparam logic [ADDR_W-1:0] A_TIM   = ADDR_W'(8'h20);

  localparam logic [4:0] PC_MR1  = 5'd16;
  localparam logic [4:0] PC_DLL  = 5'd27;
  localparam logic [4:0] PC_LAST = 5'd31;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DLY} st_t;
  typedef enum logic [2:0] {K_VLO, K_VHI, K_WR, K_AHI, K_ALO} kind_t;

  st_t               st;
  logic [4:0]        pc, nxt;
  logic [CW-1:0]     cnt, dly;
  kind_t             kind;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] data;
  logic [TW-1:0]     tidx;

  logic [FREQ_W-1:0] freq_q;
  logic [DIV_W-1:0]  n_q, m_q;
  logic [P_W-1:0]    p_q;
  logic [DATA_W-1:0] tim_q [NTIM];
  logic [DATA_W-1:0] mr0_q, mr1_q;
  logic              dll_q, gddr3_q;

  wire low = (freq_q <= FREQ_W'(LOW_SPEED_MHZ));
  wire [DATA_W-1:0] dll_bit = DATA_W'(1) << 8;

  function automatic logic [TW-1:0] tsel(logic [4:0] p);
    case (p)
      5'd18: return TW'(3);
      5'd19: return TW'(1);
      5'd20: return TW'(6);
      5'd21: return TW'(7);
      5'd22: return TW'(8);
      5'd23: return TW'(0);
      5'd24: return TW'(2);
      5'd25: return TW'(4);
      default: return TW'(5);
    endcase
  endfunction

  assign tidx = tsel(pc);

  always_comb begin
    kind = K_WR;
    addr = '0;
    data = '0;
    dly  = '0;
    case (pc)
      5'd0:  kind = K_VLO;
      5'd1:  kind = K_VHI;
      5'd2:  begin addr = A_STALL; data = DATA_W'(1); dly = CW'(D_BLOCK); end
      5'd3:  begin addr = A_FBEN;  data = '0; end
      5'd4:  begin kind = K_AHI;   dly = CW'(D_FBOFF); end
      5'd5:  begin addr = A_PRE;   data = DATA_W'(1); end
      5'd6,
      5'd7:  begin addr = A_REF;   data = DATA_W'(1); end
      5'd8:  begin addr = A_AREF;  data = '0; end
      5'd9:  begin addr = A_SREF;  data = DATA_W'(1); end
      5'd10: begin addr = A_PLLC;  data = DATA_W'({low, p_q}); end
      5'd11: begin addr = A_PLLD;  data = DATA_W'({n_q, m_q}); end
      5'd12: begin addr = A_PART;  data = DATA_W'(low); dly = CW'(D_LOCK); end
      5'd13: begin addr = A_SREF;  data = '0; end
      5'd14: begin addr = A_PRE;   data = DATA_W'(1); end
      5'd15: begin addr = A_AREF;  data = DATA_W'(1); dly = CW'(D_REFR); end
      5'd16: begin addr = A_MR1;   data = mr1_q; end
      5'd17: begin addr = A_MR0;   data = mr0_q; end
      5'd18, 5'd19, 5'd20, 5'd21, 5'd22,
      5'd23, 5'd24, 5'd25, 5'd26:
             begin addr = A_TIM + ADDR_W'(tidx); data = tim_q[tidx]; end
      5'd27: begin addr = A_MR0;   data = mr0_q | dll_bit; end
      5'd28: begin addr = A_MR0;   data = mr0_q & ~dll_bit; dly = CW'(D_DLL); end
      5'd29: begin addr = A_FBEN;  data = DATA_W'(1); end
      5'd30: kind = K_ALO;
      default: begin addr = A_STALL; data = '0; end
    endcase
  end

  always_comb begin
    nxt = pc + 5'd1;
    if (nxt == PC_MR1 && !gddr3_q) nxt = PC_MR1 + 5'd1;
    if (nxt == PC_DLL && dll_q)    nxt = PC_DLL + 5'd2;
  end

  assign busy    = (st != S_IDLE);
  assign wr_en   = (st == S_RUN) && (kind == K_WR);
  assign wr_addr = addr;
  assign wr_data = data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      pc      <= '0;
      cnt     <= '0;
      done    <= 1'b0;
      err     <= 1'b0;
      freq_q  <= '0;
      n_q     <= '0;
      m_q     <= '0;
      p_q     <= '0;
      mr0_q   <= '0;
      mr1_q   <= '0;
      dll_q   <= 1'b0;
      gddr3_q <= 1'b0;
      for (int i = 0; i < NTIM; i++) tim_q[i] <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          freq_q  <= freq_mhz;
          n_q     <= pll_n;
          m_q     <= pll_m;
          p_q     <= pll_p;
          mr0_q   <= mr0_in;
          mr1_q   <= mr1_in;
          dll_q   <= dll_off;
          gddr3_q <= mem_gddr3;
          for (int i = 0; i < NTIM; i++) tim_q[i] <= timing_in[i*DATA_W +: DATA_W];
          err <= 1'b0;
          pc  <= '0;
          st  <= S_RUN;
        end
        S_RUN: case (kind)
          K_VLO: if (!vblank) pc <= nxt;
          K_VHI: if (vblank)  pc <= nxt;
          K_WR: begin
            if (pc == PC_LAST) begin
              st   <= S_IDLE;
              done <= 1'b1;
            end else begin
              pc <= nxt;
              if (dly != '0) begin
                cnt <= dly;
                st  <= S_DLY;
              end else begin
                cnt <= CW'(ACK_TIMEOUT);
              end
            end
          end
          default: begin
            if (fb_idle == (kind == K_AHI)) begin
              pc <= nxt;
              if (dly != '0) begin
                cnt <= dly;
                st  <= S_DLY;
              end
            end else if (cnt <= CW'(1)) begin
              err <= 1'b1;
              st  <= S_IDLE;
            end else begin
              cnt <= cnt - CW'(1);
            end
          end
        endcase
        S_DLY: begin
          if (cnt <= CW'(1)) st <= S_RUN;
          else               cnt <= cnt - CW'(1);
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dram_freq_seq_chk.sv
module dram_freq_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [7:0]  wr_addr,
  input logic [31:0] wr_data,
  input logic        busy,
  input logic        done,
  input logic        err
);

  AST_WR_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> busy); // R1

  AST_FIRST_CYCLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !wr_en); // R2

  AST_REFRESH_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 8'h04) |-> $past(wr_en)); // R5

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R12

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R12

  AST_DONE_AFTER_UNSTALL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(wr_en && wr_addr == 8'h01 && wr_data == 32'h0)); // R12

  AST_ERR_GOES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> !busy); // R13

endmodule

bind dram_freq_seq dram_freq_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .busy(busy), .done(done), .err(err)
);

// File: tb/dram_freq_seq_test.sv
module dram_freq_seq_test;
  localparam int CLK_NS = 10;
  localparam int TMO    = 1024;
  localparam int NV     = 4;
  localparam int VFREQ [NV] = '{750, 751, 400, 1600};
  localparam bit VGDDR [NV] = '{1'b1, 1'b1, 1'b0, 1'b0};
  localparam bit VDLL  [NV] = '{1'b0, 1'b1, 1'b0, 1'b1};
  localparam bit VLOW  [NV] = '{1'b1, 1'b0, 1'b1, 1'b0};

  logic clk, rst_n, start, dll_off, mem_gddr3, vblank, fb_idle;
  logic [15:0] freq_mhz;
  logic [7:0]  pll_n, pll_m;
  logic [2:0]  pll_p;
  logic [287:0] timing_in;
  logic [31:0] mr0_in, mr1_in;
  logic        wr_en, busy, done, err;
  logic [7:0]  wr_addr;
  logic [31:0] wr_data;

  dram_freq_seq #(.CLK_PERIOD_NS(CLK_NS), .ACK_TIMEOUT(TMO)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .freq_mhz(freq_mhz),
    .pll_n(pll_n), .pll_m(pll_m), .pll_p(pll_p), .timing_in(timing_in),
    .mr0_in(mr0_in), .mr1_in(mr1_in), .dll_off(dll_off), .mem_gddr3(mem_gddr3),
    .vblank(vblank), .fb_idle(fb_idle), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(busy), .done(done), .err(err)
  );

  int nchk = 0, nfail = 0, cyc = 0;
  int ln = 0, done_n = 0, done_cyc = 0;
  logic [7:0]  la [64];
  logic [31:0] ld [64];
  int          lc [64];
  int en = 0;
  logic [7:0]  ea [64];
  logic [31:0] ed [64];
  int          eg [64];
  string       er [64];
  bit resp_en = 1;
  int resp_cnt = 0;
  bit resp_val = 0;

  initial begin clk = 0; forever #(CLK_NS/2) clk = ~clk; end
  initial forever @(posedge clk) cyc++;

  initial forever @(negedge clk) begin
    if (wr_en && ln < 64) begin
      la[ln] = wr_addr; ld[ln] = wr_data; lc[ln] = cyc; ln++;
    end
    if (done) begin done_n++; done_cyc = cyc; end
  end

  initial begin
    fb_idle = 0;
    forever @(negedge clk) begin
      if (wr_en && wr_addr == 8'h02) begin
        resp_cnt = 5; resp_val = (wr_data == 0);
      end else if (resp_cnt > 0) begin
        resp_cnt--;
        if (resp_cnt == 0 && resp_en) fb_idle = resp_val;
      end
    end
  end

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] tword(int k, int salt);
    return {8'(salt), 8'h5A, 8'(k), 8'(k * 17 + 3)};
  endfunction

  task automatic push(logic [7:0] a, logic [31:0] d, int g, string r);
    ea[en] = a; ed[en] = d; eg[en] = g; er[en] = r; en++;
  endtask

  task automatic build(int f, bit g, bit dll, int salt);
    int ord [9] = '{3, 1, 6, 7, 8, 0, 2, 4, 5};
    bit low = (f <= 750);
    logic [31:0] m0 = 32'h0000_0A30 + 32'(salt);
    logic [31:0] m1 = 32'h0000_0044 + 32'(salt);
    en = 0;
    push(8'h01, 32'h1, -1, "R3");
    push(8'h02, 32'h0, 801, "R3");
    push(8'h03, 32'h1, -201, "R4");
    push(8'h04, 32'h1, 1, "R5");
    push(8'h04, 32'h1, 1, "R5");
    push(8'h05, 32'h0, 1, "R5");
    push(8'h06, 32'h1, 1, "R5");
    push(8'h07, 32'(low) << 3 | 32'(salt & 7), 1, "R6");
    push(8'h08, {16'h0, 8'(8'h20 + salt), 8'(8'h03 + salt)}, 1, "R6");
    push(8'h09, 32'(low), 1, "R6");
    push(8'h06, 32'h0, 9601, "R7");
    push(8'h03, 32'h1, 1, "R8");
    push(8'h05, 32'h1, 1, "R8");
    if (g) begin
      push(8'h11, m1, 1201, "R9");
      push(8'h10, m0, 1, "R9");
    end else begin
      push(8'h10, m0, 1201, "R9");
    end
    for (int k = 0; k < 9; k++) push(8'(8'h20 + ord[k]), tword(ord[k], salt), 1, "R10");
    if (!dll) begin
      push(8'h10, m0 | 32'h100, 1, "R11");
      push(8'h10, m0 & ~32'h100, 1, "R11");
      push(8'h02, 32'h1, 2401, "R11");
    end else begin
      push(8'h02, 32'h1, 1, "R11");
    end
    push(8'h01, 32'h0, -2, "R12");
  endtask

  task automatic setup(int f, bit g, bit dll, int salt);
    freq_mhz = 16'(f); mem_gddr3 = g; dll_off = dll;
    pll_n = 8'(8'h20 + salt); pll_m = 8'(8'h03 + salt); pll_p = 3'(salt);
    mr0_in = 32'h0000_0A30 + 32'(salt); mr1_in = 32'h0000_0044 + 32'(salt);
    for (int k = 0; k < 9; k++) timing_in[k*32 +: 32] = tword(k, salt);
  endtask

  task automatic launch();
    ln = 0; done_n = 0; vblank = 1;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    chk(busy == 1, "R1", "busy after start", busy, 1);
    chk(err == 0, "R13", "err cleared by start", err, 0);
    repeat (20) @(negedge clk);
    start = 1; freq_mhz = 16'd5000; mem_gddr3 = ~mem_gddr3; dll_off = ~dll_off;
    @(negedge clk) start = 0;
    repeat (20) @(negedge clk);
    chk(ln == 0, "R2", "writes with vblank held high", ln, 0);
    vblank = 0;
    repeat (10) @(negedge clk);
    chk(ln == 0, "R2", "writes during vblank low", ln, 0);
    vblank = 1;
  endtask

  task automatic wait_idle(int lim);
    for (int i = 0; i < lim && busy; i++) @(negedge clk);
  endtask

  task automatic compare();
    chk(ln == en, "R1", "write count", ln, en);
    for (int i = 0; i < en && i < ln; i++) begin
      int gap = (i == 0) ? 0 : lc[i] - lc[i-1];
      chk(la[i] == ea[i], er[i], $sformatf("addr of write %0d", i), la[i], ea[i]);
      chk(ld[i] == ed[i], er[i], $sformatf("data of write %0d", i), ld[i], ed[i]);
      if (eg[i] > 0)
        chk(gap == eg[i], er[i], $sformatf("gap before write %0d", i), gap, eg[i]);
      else if (eg[i] < -1)
        chk(gap >= -eg[i], er[i], $sformatf("min gap before write %0d", i), gap, -eg[i]);
    end
    chk(done_n == 1, "R12", "done pulse count", done_n, 1);
    if (ln > 0) chk(done_cyc == lc[ln-1] + 1, "R12", "done cycle", done_cyc, lc[ln-1] + 1);
    chk(busy == 0, "R12", "busy at end", busy, 0);
    chk(err == 0, "R13", "err on good run", err, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end

  initial begin
    rst_n = 0; start = 0; vblank = 0;
    setup(600, 1, 0, 1);
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(busy == 0 && done == 0 && err == 0 && wr_en == 0, "R1", "reset state",
        {busy, done, err, wr_en}, 0);

    // R13: acknowledge never comes
    resp_en = 0;
    setup(600, 1, 0, 2);
    launch();
    wait_idle(TMO + 2000);
    chk(err == 1, "R13", "err after timeout", err, 1);
    chk(busy == 0, "R13", "idle after timeout", busy, 0);
    chk(ln == 2, "R13", "writes before timeout", ln, 2);
    chk(la[1] == 8'h02 && ld[1] == 0, "R13", "last write is fb off", la[1], 8'h02);
    resp_en = 1; fb_idle = 0;
    repeat (5) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      setup(VFREQ[v], VGDDR[v], VDLL[v], v + 3);
      build(VFREQ[v], VGDDR[v], VDLL[v], v + 3);
      chk(((ed[7] >> 3) & 1) == 32'(VLOW[v]), "R6", "table low-speed bit", (ed[7] >> 3) & 1, VLOW[v]);
      launch();
      wait_idle(20000);
      compare();
      repeat (5) @(negedge clk);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end
endmodule